// File: doc/BRIEF.md
# Programmable Logic Configuration Store with Read Lock

This block holds every bit that configures a small sum-of-products logic core. The bits are the connection fuses of the product-term array, two device-wide mode bits, and a mode bit plus an output polarity bit for each macrocell. Beside them sit a 64-bit user signature and a one-way security bit. An external programmer drives a command strobe and a one-bit serial shift path. Through these it loads a full image, reads back the protected configuration, reads the signature, sets security, or bulk-erases the store. The committed configuration is presented in parallel to the logic core.

Security protects the configuration against copying. Once set, a readback of the fuses and mode bits returns only zeros, and further loads are refused. The signature stays readable. The only way to clear security is an erase, which also returns every stored bit to the unprogrammed level.

Top module: `cfg_store`

## Requirements
- R1: After reset, every stored bit (fuses, mode, polarity, signature) is at the erased level 1, `sec_locked` is 0, `busy` is 0 and `sdo` is 0.
- R2: A command is taken when `cmd_valid` is high and `busy` is low. The codes on `cmd_op` are 1 load, 2 read configuration, 3 read signature, 4 set security and 5 erase, and any other code does nothing. A load accepts 2642 bits on `sdi`, one for each cycle with `shift_en` high, and the k-th bit becomes image bit k. The image is laid out as follows: fuses at 0..2559; global mode bits at 2560 (`glb_mode[0]`) and 2561; macrocell i mode at 2562+i; macrocell i polarity at 2570+i; signature at 2578..2641.
- R3: The parallel outputs keep their old value throughout a load. They take the new image at the clock edge that takes the last bit, and `busy` falls at that same edge.
- R4: A read-configuration command streams image bits 0..2577 on `sdo`, one per `shift_en` cycle. `sdo` is registered and shows bit k after the k-th shift edge.
- R5: A read-signature command streams image bits 2578..2641 in the same way.
- R6: A set-security command raises `sec_locked` at the accepting edge. Every later configuration readback then shifts out zeros only.
- R7: The signature read returns the true signature whether or not security is set.
- R8: A load command while `sec_locked` is 1 is dropped: `busy` stays 0 and the parallel outputs are unchanged even if bits are shifted in.
- R9: An erase command sets every stored bit to 1 and clears `sec_locked`, both at the accepting edge.
- R10: No command except erase clears `sec_locked`.
- R11: A command offered while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, returns a blank store |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| shift_en | input | 1 | One serial bit moves on this cycle |
| sdi | input | 1 | Serial load data |
| sdo | output | 1 | Serial readback data, registered |
| busy | output | 1 | A load or read transfer is in progress |
| sec_locked | output | 1 | Security bit |
| fuse_map | output | 2560 | Committed product-term fuses |
| glb_mode | output | 2 | Committed global mode bits |
| mc_mode | output | 8 | Committed macrocell mode bits |
| mc_pol | output | 8 | Committed macrocell polarity bits |

## Verification
The bench loads random images and probes the parallel outputs one cycle before the final bit. A design that committed early, or that updated the outputs as bits shifted in, would show the new fuses there. With security set, the bench reads both regions and tries a load while shifting bits. A leaking design would return fuse data, a design that locked too much would zero the signature, and one that did not refuse the load would overwrite the image. The bench offers set-security in the middle of a load, which would lock a design that failed to ignore commands while busy. It also checks that erase alone restores the all-ones image and unlocks the store.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_READ   = 3'd2,
    OP_RDSIG  = 3'd3,
    OP_SECURE = 3'd4,
    OP_ERASE  = 3'd5
  } cs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_READ,
    ST_RDSIG
  } cs_state_e;
endpackage

// File: rtl/cfg_cmd_fsm.sv
module cfg_cmd_fsm
  import cfgstore_pkg::*;
#(
  parameter int IMG_BITS  = 2642,
  parameter int PROT_BITS = 2578,
  parameter int SIG_BITS  = 64,
  localparam int CW = $clog2(IMG_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          shift_en,
  input  logic          secure,
  output cs_state_e     state,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          shift_ld,
  output logic          commit,
  output logic          rd_strobe,
  output logic          set_go,
  output logic          erase_go
);
  logic accept, load_go, read_go, rdsig_go, last;

  assign busy     = (state != ST_IDLE);
  assign accept   = cmd_valid && !busy;
  assign load_go  = accept && (cmd_op == OP_LOAD) && !secure;
  assign read_go  = accept && (cmd_op == OP_READ);
  assign rdsig_go = accept && (cmd_op == OP_RDSIG);
  assign set_go   = accept && (cmd_op == OP_SECURE);
  assign erase_go = accept && (cmd_op == OP_ERASE);

  always_comb begin
    case (state)
      ST_LOAD:  last = (cnt == CW'(IMG_BITS - 1));
      ST_READ:  last = (cnt == CW'(PROT_BITS - 1));
      ST_RDSIG: last = (cnt == CW'(SIG_BITS - 1));
      default:  last = 1'b0;
    endcase
  end

  assign shift_ld  = (state == ST_LOAD) && shift_en;
  assign commit    = shift_ld && last;
  assign rd_strobe = ((state == ST_READ) || (state == ST_RDSIG)) && shift_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (load_go)       state <= ST_LOAD;
          else if (read_go)  state <= ST_READ;
          else if (rdsig_go) state <= ST_RDSIG;
        end
        default: begin
          if (shift_en) begin
            if (last) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R8: a load offered while locked never starts a transfer
  p_locked_load_dropped_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == OP_LOAD && secure) |=> !busy);

  // R11: while busy only the final shift may end the transfer
  p_busy_cmd_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !(shift_en && last)) |=> ($stable(state) && busy));

  // R2: the bit counter never runs past the image length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CW'(IMG_BITS)));
endmodule

// File: rtl/cfg_image.sv
module cfg_image #(
  parameter int IMG_BITS   = 2642,
  parameter bit ERASED_BIT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_ld,
  input  logic                sdi,
  input  logic                commit,
  input  logic                erase_go,
  output logic [IMG_BITS-1:0] img
);
  logic [IMG_BITS-1:0] stage, stage_nxt;

  assign stage_nxt = {sdi, stage[IMG_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      img   <= {IMG_BITS{ERASED_BIT}};
    end else begin
      if (shift_ld) stage <= stage_nxt;
      if (erase_go)    img <= {IMG_BITS{ERASED_BIT}};
      else if (commit) img <= stage_nxt;
    end
  end

  // R9: erase leaves the whole image at the erased level
  p_erase_blank_r9: assert property (@(posedge clk) disable iff (rst)
    erase_go |=> (img == {IMG_BITS{ERASED_BIT}}));
endmodule

// File: rtl/cfg_security.sv
module cfg_security (
  input  logic clk,
  input  logic rst,
  input  logic set_go,
  input  logic erase_go,
  output logic sec
);
  always_ff @(posedge clk) begin
    if (rst)           sec <= 1'b0;
    else if (erase_go) sec <= 1'b0;
    else if (set_go)   sec <= 1'b1;
  end

  // R10: the lock only drops after an accepted erase
  p_sec_clear_erase_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(sec) |-> $past(erase_go));

  // R6: set-security locks on the next edge
  p_sec_set_r6: assert property (@(posedge clk) disable iff (rst)
    (set_go && !erase_go) |=> sec);
endmodule

// File: rtl/cfg_readout.sv
module cfg_readout #(
  parameter int IMG_BITS  = 2642,
  parameter int PROT_BITS = 2578,
  localparam int CW = $clog2(IMG_BITS + 1),
  localparam int IW = $clog2(IMG_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_strobe,
  input  logic                sel_sig,
  input  logic [CW-1:0]       cnt,
  input  logic                secure,
  input  logic [IMG_BITS-1:0] img,
  output logic                sdo
);
  logic [IW-1:0] idx;
  logic          bit_sel;

  assign idx = IW'(cnt) + (sel_sig ? IW'(PROT_BITS) : IW'(0));

  always_comb begin
    bit_sel = img[idx];
    if (!sel_sig && secure) bit_sel = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            sdo <= 1'b0;
    else if (rd_strobe) sdo <= bit_sel;
  end

  // R6: locked configuration readback carries no data
  p_locked_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !sel_sig && secure) |=> !sdo);
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfgstore_pkg::*;
#(
  parameter int NUM_MC       = 8,
  parameter int PT_PER_MC    = 8,
  parameter int ARRAY_INPUTS = 40,
  parameter int SIG_BITS     = 64,
  parameter bit ERASED_BIT   = 1'b1,
  localparam int FUSE_BITS = NUM_MC * PT_PER_MC * ARRAY_INPUTS,
  localparam int GLB_BITS  = 2,
  localparam int CTRL_BITS = GLB_BITS + 2 * NUM_MC,
  localparam int PROT_BITS = FUSE_BITS + CTRL_BITS,
  localparam int IMG_BITS  = PROT_BITS + SIG_BITS,
  localparam int CW        = $clog2(IMG_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic                 shift_en,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 busy,
  output logic                 sec_locked,
  output logic [FUSE_BITS-1:0] fuse_map,
  output logic [GLB_BITS-1:0]  glb_mode,
  output logic [NUM_MC-1:0]    mc_mode,
  output logic [NUM_MC-1:0]    mc_pol
);
  cs_state_e           state;
  logic [CW-1:0]       cnt;
  logic                shift_ld, commit, rd_strobe, set_go, erase_go;
  logic [IMG_BITS-1:0] img;

  cfg_cmd_fsm #(.IMG_BITS(IMG_BITS), .PROT_BITS(PROT_BITS), .SIG_BITS(SIG_BITS)) u_fsm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .shift_en(shift_en), .secure(sec_locked), .state(state), .cnt(cnt),
    .busy(busy), .shift_ld(shift_ld), .commit(commit), .rd_strobe(rd_strobe),
    .set_go(set_go), .erase_go(erase_go)
  );

  cfg_image #(.IMG_BITS(IMG_BITS), .ERASED_BIT(ERASED_BIT)) u_img (
    .clk(clk), .rst(rst), .shift_ld(shift_ld), .sdi(sdi),
    .commit(commit), .erase_go(erase_go), .img(img)
  );

  cfg_security u_sec (
    .clk(clk), .rst(rst), .set_go(set_go), .erase_go(erase_go), .sec(sec_locked)
  );

  cfg_readout #(.IMG_BITS(IMG_BITS), .PROT_BITS(PROT_BITS)) u_rd (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .sel_sig(state == ST_RDSIG),
    .cnt(cnt), .secure(sec_locked), .img(img), .sdo(sdo)
  );

  assign fuse_map = img[FUSE_BITS-1:0];
  assign glb_mode = img[FUSE_BITS +: GLB_BITS];

  for (genvar i = 0; i < NUM_MC; i++) begin : g_mc
    assign mc_mode[i] = img[FUSE_BITS + GLB_BITS + i];
    assign mc_pol[i]  = img[FUSE_BITS + GLB_BITS + NUM_MC + i];
  end

  // R3: the core sees new fuses only at the end of a load or after an erase
  p_no_partial_update_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(fuse_map) |-> ($fell(busy) ||
      $past(cmd_valid && !busy && cmd_op == OP_ERASE)));
endmodule

// File: tb/tb_cfg_store.sv
module tb_cfg_store;
  localparam int F    = 2560;
  localparam int PROT = 2578;
  localparam int IMG  = 2642;
  localparam int SIG  = 64;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0, shift_en = 1'b0, sdi = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic sdo, busy, sec_locked;
  logic [F-1:0] fuse_map;
  logic [1:0] glb_mode;
  logic [7:0] mc_mode, mc_pol;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  cfg_store dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .shift_en(shift_en), .sdi(sdi), .sdo(sdo), .busy(busy),
    .sec_locked(sec_locked), .fuse_map(fuse_map), .glb_mode(glb_mode),
    .mc_mode(mc_mode), .mc_pol(mc_pol)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [IMG-1:0] rand_img();
    logic [IMG-1:0] v;
    for (int k = 0; k < IMG; k++) v[k] = 1'($urandom % 2);
    return v;
  endfunction

  function automatic int img_diff(logic [IMG-1:0] im);
    logic [PROT-1:0] seen;
    seen = {mc_pol, mc_mode, glb_mode, fuse_map};
    return $countones(seen ^ im[PROT-1:0]);
  endfunction

  function automatic logic [IMG-1:0] exp_readback(logic [IMG-1:0] im, bit locked);
    logic [IMG-1:0] v;
    v = '0;
    if (!locked) v[PROT-1:0] = im[PROT-1:0];
    return v;
  endfunction

  task automatic issue(logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
  endtask

  // inject_op: 0 none, else a command offered mid-transfer
  task automatic do_load(string req, logic [IMG-1:0] im, logic [IMG-1:0] prev,
                         bit expect_commit, logic [2:0] inject_op);
    issue(3'd1);
    chk(req, busy == expect_commit, "busy after load cmd", busy, expect_commit);
    for (int k = 0; k < IMG; k++) begin
      sdi = im[k];
      shift_en = 1'b1;
      if (k == 5 && inject_op != 3'd0) begin
        cmd_valid = 1'b1;
        cmd_op    = inject_op;
      end else begin
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
      end
      if (k == IMG - 1) begin
        // R3: one edge before the final bit nothing has been committed
        chk("R3", img_diff(prev) == 0, "outputs before last bit (diff bits)", img_diff(prev), 0);
      end
      @(negedge clk);
    end
    shift_en = 1'b0;
    chk(req, busy == 1'b0, "busy after last bit", busy, 0);
    if (expect_commit)
      chk(req, img_diff(im) == 0, "committed image (diff bits)", img_diff(im), 0);
    else
      chk(req, img_diff(prev) == 0, "image unchanged (diff bits)", img_diff(prev), 0);
  endtask

  task automatic do_read(string req, logic [2:0] op, int len, logic [IMG-1:0] exp);
    logic [IMG-1:0] got;
    got = '0;
    issue(op);
    for (int k = 0; k < len; k++) begin
      shift_en = 1'b1;
      @(negedge clk);
      got[k] = sdo;
    end
    shift_en = 1'b0;
    chk(req, $countones(got ^ exp) == 0, "serial readback (diff bits)",
        $countones(got ^ exp), 0);
  endtask

  function automatic logic [IMG-1:0] sig_of(logic [IMG-1:0] im);
    logic [IMG-1:0] v;
    v = '0;
    v[SIG-1:0] = im[IMG-1:PROT];
    return v;
  endfunction

  initial begin
    logic [IMG-1:0] cur, nxt, ones;
    void'($urandom(32'd20240611));
    ones = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: blank store after reset
    chk("R1", img_diff(ones) == 0, "reset image (diff bits)", img_diff(ones), 0);
    chk("R1", {busy, sec_locked, sdo} == 3'b000, "busy/lock/sdo", {busy, sec_locked, sdo}, 0);
    cur = ones;
    do_read("R5", 3'd3, SIG, sig_of(cur));

    // R2/R4/R5: random images
    for (int n = 0; n < 3; n++) begin
      nxt = rand_img();
      do_load("R2", nxt, cur, 1'b1, 3'd0);
      cur = nxt;
      chk("R2", {mc_pol, mc_mode, glb_mode} == cur[PROT-1:F], "control bits",
          {mc_pol, mc_mode, glb_mode}, cur[PROT-1:F]);
      do_read("R4", 3'd2, PROT, exp_readback(cur, 1'b0));
      do_read("R5", 3'd3, SIG, sig_of(cur));
    end

    // directed: all-zero image
    nxt = '0;
    do_load("R2", nxt, cur, 1'b1, 3'd0);
    cur = nxt;
    do_read("R4", 3'd2, PROT, exp_readback(cur, 1'b0));

    // R11: set-security offered mid-load is ignored
    nxt = rand_img();
    do_load("R11", nxt, cur, 1'b1, 3'd4);
    cur = nxt;
    chk("R11", sec_locked == 1'b0, "lock after busy cmd", sec_locked, 0);

    // undefined code does nothing
    issue(3'd7);
    chk("R2", {busy, sec_locked} == 2'b00 && img_diff(cur) == 0, "undefined op effect",
        {busy, sec_locked}, 0);

    // R6: lock
    issue(3'd4);
    chk("R6", sec_locked == 1'b1, "lock after set", sec_locked, 1);
    do_read("R6", 3'd2, PROT, exp_readback(cur, 1'b1));
    // R7: signature still visible
    do_read("R7", 3'd3, SIG, sig_of(cur));

    // R8: load while locked is dropped
    nxt = rand_img();
    do_load("R8", nxt, cur, 1'b0, 3'd0);

    // R10: other commands leave the lock set
    issue(3'd4);
    issue(3'd2);
    repeat (PROT) begin shift_en = 1'b1; @(negedge clk); end
    shift_en = 1'b0;
    issue(3'd0);
    chk("R10", sec_locked == 1'b1, "lock after non-erase cmds", sec_locked, 1);

    // R9: erase
    issue(3'd5);
    cur = ones;
    chk("R9", img_diff(cur) == 0, "erased image (diff bits)", img_diff(cur), 0);
    chk("R9", sec_locked == 1'b0, "lock after erase", sec_locked, 0);
    do_read("R9", 3'd3, SIG, sig_of(cur));
    do_read("R9", 3'd2, PROT, exp_readback(cur, 1'b0));

    // reload after erase
    nxt = rand_img();
    do_load("R8", nxt, cur, 1'b1, 3'd0);
    cur = nxt;
    do_read("R4", 3'd2, PROT, exp_readback(cur, 1'b0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule